// File: doc/BRIEF.md
# External Trigger Edge Counter Front-End

This block lets an asynchronous trigger pin act as the count clock of a 16-bit up-counter. The pin is brought into the system clock domain by a two-flop synchroniser. Its polarity can then be inverted, so either rising or falling pin edges can be chosen as the active edge. The conditioned level next passes through an optional digital glitch filter, which is a reloading down-counter that samples once per system clock. Active edges of the filtered level then feed a prescaler, which divides them by 1, 2, 4 or 8. On each wrap the prescaler emits a one-cycle tick.

A mode bit picks the counter's increment source. When the bit is set, the counter steps on each tick. When it is clear, the counter steps on every system clock. In both modes the counter moves only while the run bit is high.

After reset, a short warm-up window loads the filter and the edge detector from the settled pin level. Because of this, a pin that sits at its active level during reset does not produce a count.

Top module: `ext_trig_counter`

## Requirements
- R1: With the filter field at 0 and the prescaler code at 00, the counter changes on the third rising system clock edge after an active pin edge and not earlier.
- R2: Polarity bit 0 makes low-to-high pin transitions active. Polarity bit 1 makes high-to-low pin transitions active, and low-to-high transitions are then not counted.
- R3: Prescaler code 00/01/10/11 yields one tick per 1/2/4/8 active edges, so after k active edges from reset the counter (external mode) holds k >> code.
- R4: Any change of the prescaler code clears the count of edges seen so far; the next tick comes after a full new group of edges.
- R5: Filter field 0 bypasses the filter. Filter values 1, 2 and 3 require 2, 4 and 8 consecutive samples at a new level before the filtered level follows it, and values 4 to 15 require 8. With filter field 1 and prescaler /1, the counter changes on the fifth clock edge after the pin edge.
- R6: A pin pulse shorter than the filter's sample count is not counted, and a longer one is counted once.
- R7: With the mode bit at 1, the counter advances by one per tick only. With the mode bit at 0, it advances by one on every clock edge.
- R8: While the run bit is 0, the counter holds its value whatever the pin does.
- R9: The counter is 0 after reset and steps from 0xFFFF to 0x0000.
- R10: The tick output is never high for two consecutive cycles.
- R11: A pin held steady at the active level through reset and the following four clocks produces no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous trigger pin |
| ext_mode_i | input | 1 | 1: count ticks of the pin path, 0: count system clocks |
| pol_i | input | 1 | 0: rising pin edges active, 1: falling pin edges active |
| psc_i | input | 2 | Edge divider code: 00 /1, 01 /2, 10 /4, 11 /8 |
| filt_i | input | 4 | Glitch filter setting, 0 disables filtering |
| cen_i | input | 1 | Counter run enable |
| tick_o | output | 1 | One-cycle pulse per prescaled, filtered active edge |
| cnt_o | output | 16 | Counter value |

## Verification
The hardest case to reach from the ports is an edge arriving near a change of state deep in the pipeline. Two examples are a prescaler group that is only partly filled when the divider code is rewritten, and a filter whose down-counter is part-way through a run of samples when the pin falls back. The bench reaches the first by delivering three edges at /4 and then switching to /2. It reaches the second with pulses one sample shorter than the filter length, followed by one pulse that is long enough. Random segments with a fixed seed cover every polarity, divider and filter setting, using pulse widths drawn just above the filter length. Directed latency probes sample the counter on each clock edge after a pin edge.

// File: rtl/etr_pkg.sv
package etr_pkg;
  typedef enum logic [1:0] {
    PSC_DIV1 = 2'b00,
    PSC_DIV2 = 2'b01,
    PSC_DIV4 = 2'b10,
    PSC_DIV8 = 2'b11
  } psc_e;

  // reload value of filter down-counter = required samples - 1
  function automatic logic [2:0] filt_reload(input logic [3:0] f);
    case (f)
      4'd0:    return 3'd0;
      4'd1:    return 3'd1;
      4'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] psc_limit(input logic [1:0] p);
    return 3'((4'd1 << p) - 4'd1);
  endfunction
endpackage

// File: rtl/etr_sync.sv
module etr_sync #(
  parameter int STAGES = 2,
  parameter int WARM   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic ready_o
);
  localparam int WARM_W = $clog2(WARM + 1);

  logic [STAGES-1:0] sync_q;
  logic [WARM_W-1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        warm_q <= '0;
    else if (warm_q != WARM_W'(WARM))   warm_q <= warm_q + 1'b1;
  end

  assign lvl_o   = sync_q[STAGES-1] ^ inv_i;
  assign ready_o = (warm_q == WARM_W'(WARM));

  // R11: once warmed up, stays warmed up until reset
  a_r11_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: rtl/etr_filter.sv
module etr_filter
  import etr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       ready_i,
  input  logic [3:0] cfg_i,
  output logic       lvl_o
);
  logic [2:0] cnt_q;
  logic       out_q;
  logic [2:0] reload;

  assign reload = filt_reload(cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (!ready_i || lvl_i == out_q) begin
      if (!ready_i) out_q <= lvl_i;  // preload from settled pin
      cnt_q <= reload;
    end else if (cnt_q == '0) begin
      out_q <= lvl_i;
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign lvl_o = (cfg_i == 4'd0) ? lvl_i : out_q;

  // R5: a disagreeing sample before the count runs out leaves the level alone
  a_r5_hold_until_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && lvl_i != out_q && cnt_q != '0) |=> $stable(out_q));
endmodule

// File: rtl/etr_presc.sv
module etr_presc
  import etr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       ready_i,
  input  logic [1:0] psc_i,
  output logic       tick_o
);
  logic       prev_q;
  logic [1:0] psc_q;
  logic [2:0] cnt_q;
  logic       rise, same, wrap;
  logic [2:0] lim;

  assign lim  = psc_limit(psc_i);
  assign rise = ready_i & lvl_i & ~prev_q;
  assign same = (psc_i == psc_q);
  assign wrap = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      psc_q  <= PSC_DIV1;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      psc_q  <= psc_i;
      if (!same)     cnt_q <= '0;       // new divider: restart group
      else if (rise) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = rise & same & wrap;

  a_r10_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r3_group_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same |-> cnt_q <= lim);
endmodule

// File: rtl/ext_trig_counter.sv
module ext_trig_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             ext_mode_i,
  input  logic             pol_i,
  input  logic [1:0]       psc_i,
  input  logic [3:0]       filt_i,
  input  logic             cen_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int WARM = SYNC_STAGES + 2;

  logic sync_lvl, ready, filt_lvl, tick;
  logic [CNT_W-1:0] cnt_q;

  etr_sync #(.STAGES(SYNC_STAGES), .WARM(WARM)) u_sync (
    .clk_i, .rst_ni, .pin_i, .inv_i(pol_i), .lvl_o(sync_lvl), .ready_o(ready));

  etr_filter u_filt (
    .clk_i, .rst_ni, .lvl_i(sync_lvl), .ready_i(ready), .cfg_i(filt_i),
    .lvl_o(filt_lvl));

  etr_presc u_psc (
    .clk_i, .rst_ni, .lvl_i(filt_lvl), .ready_i(ready), .psc_i,
    .tick_o(tick));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (cen_i && (!ext_mode_i || tick))   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = tick;
  assign cnt_o  = cnt_q;

  a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_i |=> $stable(cnt_o));
  a_r7_ext_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !tick_o) |=> $stable(cnt_o));
  a_r9_wraps_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && !ext_mode_i && cnt_o == '1) |=> cnt_o == '0);
endmodule

// File: tb/sim_ext_trig_counter.sv
`timescale 1ns/1ps
module sim_ext_trig_counter;
  logic clk = 1'b0, rst_ni = 1'b0, pin = 1'b0, mode = 1'b1, pol = 1'b0, cen = 1'b1;
  logic [1:0] psc = 2'd0;
  logic [3:0] filt = 4'd0;
  logic tick;
  logic [15:0] cnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_trig_counter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .ext_mode_i(mode), .pol_i(pol),
    .psc_i(psc), .filt_i(filt), .cen_i(cen), .tick_o(tick), .cnt_o(cnt));

  function automatic int nsamp(input int f);
    if (f == 0) return 0;
    if (f == 1) return 2;
    if (f == 2) return 4;
    return 8;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pin = ~pol; repeat (hi) @(negedge clk);
    pin = pol;  repeat (lo) @(negedge clk);
  endtask

  initial begin
    int c0;
    void'($urandom(32'h1d0c));
    // reset state (R9)
    repeat (2) @(negedge clk);
    check("R9 reset count", cnt, 0);
    check("R10 reset tick", tick, 0);

    // R1 latency, filter off, /1
    do_reset();
    c0 = cnt;
    pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 no change after 2 edges", cnt, c0);
    @(negedge clk);
    check("R1 change on 3rd edge", cnt, c0 + 1);
    pin = 1'b0; repeat (4) @(negedge clk);

    // R5 latency with filter 1
    filt = 4'd1; do_reset();
    c0 = cnt; pin = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 no change after 4 edges", cnt, c0);
    @(negedge clk);
    check("R5 change on 5th edge", cnt, c0 + 1);
    pin = 1'b0; repeat (6) @(negedge clk);

    // R2 falling edges with polarity 1
    filt = 4'd0; pol = 1'b1; pin = 1'b1; do_reset();
    c0 = cnt; pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 falling edge counted", cnt, c0 + 1);
    pin = 1'b1; repeat (6) @(negedge clk);
    check("R2 rising edge ignored", cnt, c0 + 1);

    // R11 pin at active level through reset
    pol = 1'b0; filt = 4'd5; pin = 1'b1; do_reset();
    repeat (12) @(negedge clk);
    check("R11 no count from reset level", cnt, 0);
    pin = 1'b0; repeat (12) @(negedge clk);

    // R4 divider rewrite clears the partial group
    filt = 4'd0; psc = 2'd2; do_reset();
    repeat (3) pulse(3, 3);
    check("R4 partial /4 group", cnt, 0);
    psc = 2'd1; repeat (3) @(negedge clk);
    pulse(3, 3);
    check("R4 first edge after rewrite", cnt, 0);
    pulse(3, 3);
    check("R4 second edge after rewrite", cnt, 1);

    // R6 glitch rejection, filter value 9 -> 8 samples
    filt = 4'd9; psc = 2'd0; do_reset();
    repeat (4) pulse(7, 10);
    check("R6 short pulses rejected", cnt, 0);
    pulse(10, 12);
    check("R6 long pulse counted", cnt, 1);

    // R3/R5 random segments
    for (int s = 0; s < 10; s++) begin
      int n, w, nf;
      pol = 1'($urandom % 2); psc = 2'($urandom % 4); filt = 4'($urandom % 16);
      pin = pol; do_reset();
      nf = nsamp(filt); w = (nf + 2 < 2) ? 2 : nf + 2;
      n = 3 + $urandom % 12;
      for (int i = 0; i < n; i++) pulse(w + $urandom % 4, w + $urandom % 4);
      repeat (nf + 6) @(negedge clk);
      check($sformatf("R3 R5 seg%0d psc%0d filt%0d", s, psc, filt), cnt, n >> psc);
    end

    // R8 run bit low holds count
    pol = 1'b0; psc = 2'd0; filt = 4'd0; pin = 1'b0; do_reset();
    cen = 1'b0;
    repeat (4) pulse(3, 3);
    check("R8 hold while disabled", cnt, 0);

    // R7 internal clock mode
    mode = 1'b0; do_reset();
    cen = 1'b1; repeat (37) @(negedge clk);
    cen = 1'b0; repeat (3) @(negedge clk);
    check("R7 internal mode counts clocks", cnt, 37);

    // R9 wrap
    do_reset();
    cen = 1'b1; repeat (65535) @(negedge clk);
    check("R9 reaches max", cnt, 16'hFFFF);
    @(negedge clk);
    check("R9 wraps to zero", cnt, 0);
    cen = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // R10: tick never two cycles in a row
  logic tick_d = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && tick && tick_d) begin
      checks++; errors++;
      $display("FAIL R10: actual tick high twice expected single pulse");
    end
    tick_d <= tick;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule